// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Sequencer

This block decides, one clock at a time, when the power switch of a quasi-resonant converter turns on and when it turns off. It watches a valley-detect pulse from the drain-ringing comparator, an on-time-complete flag from the external constant-on-time comparator, a current-limit comparator flag and a digitized peak current-sense code. From these it drives one gate-request line. Each switching cycle is opened either by a qualified valley or by one of two fallback timers. It is closed by the on-time comparator, the current limit or the on-time clamps.

All timing is counted in clock cycles from the rising edge of the previous gate pulse. Valleys that come too early are not used for turn-on, but they are remembered and arm a short fallback timer. A long starter timer ends any cycle in which no valley qualifies. After every turn-off, valley detection is blanked for a time that grows with the peak current code sampled at that turn-off. A protection enable holds the gate low and clears every timer. After enable returns, the first cycle is always started by the starter timer.

The valley input is asynchronous and passes through a synchronizer. The comparator flags and the peak code are taken to be synchronous to the clock. The default parameters assume a 50 MHz clock and a peak code of 10 mV per LSB.

Top module: `qr_cycle_sequencer`

## Requirements
- R1: While `rst` is high, and on the first clock edge with `enable` low, `gate`, `cycle_start` and `cycle_end` are all driven low, and every timer and every remembered valley is cleared. The one exception is `cycle_end`: it pulses for one cycle when `enable` drops while the gate is high.
- R2: After reset or after `enable` returns high, the first gate rise comes START_CYC clock edges after the first edge that sees `enable` high. Valley pulses before that rise are not used.
- R3: A valley event that the period counter sees at count ≥ MIN_PERIOD_CYC−1 (counting from 0 in the first gate-high cycle) starts the next gate pulse on the next edge. A `valley_in` pulse that is set up before edge n therefore raises `gate` at edge n+2 (two synchronizer flops, then the gate register).
- R4: The rise-to-rise period is never shorter than MIN_PERIOD_CYC cycles. A valley event seen before the window opens does not start a pulse.
- R5: If at least one valley event was seen before the window opened and none has come since, the gate rises so that the period is exactly MIN_PERIOD_CYC+EXT_CYC cycles.
- R6: If no valley event was seen in the cycle, the gate rises so that the period is exactly START_CYC cycles.
- R7: A gate pulse lasts at least ON_MIN_CYC cycles, even when `on_done` is high from the first gate-high cycle.
- R8: A gate pulse lasts at most ON_MAX_CYC cycles, even when `on_done` and `cur_limit` stay low.
- R9: If `on_done` is high in gate-high cycle k (numbered from 0) and k ≥ ON_MIN_CYC−1, the pulse width is k+1 cycles.
- R10: `cur_limit` has no effect in gate-high cycles 0 to LEB_CYC−1. When it is high in cycle k ≥ LEB_CYC, the pulse width is k+1 cycles, even if this is shorter than ON_MIN_CYC.
- R11: For the first BLANK_BASE_CYC + `peak_code`·BLANK_PER_CODE_CYC low cycles after a turn-off, valley events have no effect, either as turn-on triggers or as arming of the R5 fallback. Here `peak_code` is the value sampled at the turn-off edge. Valley events while the gate is high also have no effect.
- R12: `cycle_start` is high in exactly the first gate-high cycle of each pulse. `cycle_end` is high in exactly the first gate-low cycle after a pulse.
- R13: A `valley_in` pulse that stays high for many cycles counts as exactly one valley event, taken from its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Protection enable; low forces the gate off and clears all timers |
| valley_in | input | 1 | Asynchronous valley-detect pulse |
| on_done | input | 1 | Constant-on-time comparator says the on-time is complete |
| cur_limit | input | 1 | Cycle-by-cycle current-limit comparator flag |
| peak_code | input | CODE_W | Peak current-sense code, sampled at turn-off |
| gate | output | 1 | Registered gate request |
| cycle_start | output | 1 | One-cycle strobe in the first gate-high cycle |
| cycle_end | output | 1 | One-cycle strobe in the first gate-low cycle after a pulse |

## Verification
A turn-off condition shows on `gate` one edge after the cycle in which it holds, so a pulse whose condition first holds in gate-high cycle k is k+1 cycles wide. A valley pulse reaches `gate` two edges after it is first sampled, so a valley driven in cycle k ends the period at k+3. Both strobes change on the same edge as `gate`. The bench drives every input and samples every output on the falling clock edge, counts gate-high cycles from the rise, and compares the width and period with table values computed from these latencies. The blanking rows sit one cycle on either side of each boundary, so that a one-cycle slip is caught.

// File: rtl/qr_seq_pkg.sv
package qr_seq_pkg;

  // Bits needed to hold values 0..max_val.
  function automatic int cnt_w(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  typedef enum logic {
    PH_OFF = 1'b0,
    PH_ON  = 1'b1
  } gate_phase_e;

endpackage

// File: rtl/qr_valley_edge.sv
module qr_valley_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_async_i,
  output logic rise_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pulse_async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[MSB-1:0], pulse_async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[MSB];
  end

  assign rise_o = sync_q[MSB] & ~last_q;

  // A held level yields only a single event cycle
  assert_single_event_R13: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/qr_valley_blank.sv
module qr_valley_blank
  import qr_seq_pkg::*;
#(
  parameter int BLANK_BASE_CYC     = 100,
  parameter int BLANK_PER_CODE_CYC = 1,
  parameter int CODE_W             = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              active_o
);
  localparam int MAXV = BLANK_BASE_CYC + ((1 << CODE_W) - 1) * BLANK_PER_CODE_CYC;
  localparam int BW   = cnt_w(MAXV);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= BW'(BLANK_BASE_CYC) + BW'(code_i) * BW'(BLANK_PER_CODE_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = (cnt_q != '0);

  // Blank window shrinks by exactly one per cycle until it closes
  assert_blank_countdown_R11: assert property (@(posedge clk) disable iff (rst)
    (en_i && !load_i && cnt_q != '0) |=> (!en_i || cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/qr_period_timer.sv
module qr_period_timer
  import qr_seq_pkg::*;
#(
  parameter int MIN_PERIOD_CYC = 425,
  parameter int EXT_CYC        = 250,
  parameter int START_CYC      = 6500
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic gate_i,
  input  logic valley_i,
  output logic launch_o
);
  localparam int TOPV = START_CYC + MIN_PERIOD_CYC + EXT_CYC;
  localparam int PW   = cnt_w(TOPV);
  localparam logic [PW-1:0] SMIN_M1 = PW'(MIN_PERIOD_CYC - 1);
  localparam logic [PW-1:0] FB_M1   = PW'(MIN_PERIOD_CYC + EXT_CYC - 1);
  localparam logic [PW-1:0] ST_M1   = PW'(START_CYC - 1);
  localparam logic [PW-1:0] SAT     = PW'(TOPV);

  logic [PW-1:0] period_q;
  logic          seen_early_q;
  logic          primed_q;
  logic          win_open;
  logic          fb_due;
  logic          st_due;

  assign win_open = (period_q >= SMIN_M1);
  assign fb_due   = seen_early_q && (period_q >= FB_M1);
  assign st_due   = (period_q >= ST_M1);
  assign launch_o = en_i && !gate_i &&
                    (st_due || (primed_q && ((valley_i && win_open) || fb_due)));

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      period_q     <= '0;
      seen_early_q <= 1'b0;
      primed_q     <= 1'b0;
    end else if (launch_o) begin
      period_q     <= '0;
      seen_early_q <= 1'b0;
      primed_q     <= 1'b1;
    end else begin
      if (period_q != SAT) period_q <= period_q + 1'b1;
      if (primed_q && valley_i && !win_open && !gate_i) seen_early_q <= 1'b1;
    end
  end

  // No turn-on before the minimum period has elapsed
  assert_min_period_R4: assert property (@(posedge clk) disable iff (rst)
    launch_o |-> (period_q >= SMIN_M1));

  // Starter always fires once its interval is used up
  assert_starter_fires_R6: assert property (@(posedge clk) disable iff (rst)
    (en_i && !gate_i && period_q >= ST_M1) |-> launch_o);

  // The first turn-on after enable comes from the starter alone
  assert_first_by_starter_R2: assert property (@(posedge clk) disable iff (rst)
    (launch_o && !primed_q) |-> (period_q == ST_M1));

endmodule

// File: rtl/qr_ontime_ctrl.sv
module qr_ontime_ctrl
  import qr_seq_pkg::*;
#(
  parameter int ON_MIN_CYC = 63,
  parameter int ON_MAX_CYC = 2350,
  parameter int LEB_CYC    = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_i,
  input  logic ton_done_i,
  input  logic ilim_i,
  output logic off_req_o
);
  localparam int OW = cnt_w(ON_MAX_CYC + LEB_CYC + ON_MIN_CYC);
  localparam logic [OW-1:0] MIN_M1 = OW'(ON_MIN_CYC - 1);
  localparam logic [OW-1:0] MAX_M1 = OW'(ON_MAX_CYC - 1);
  localparam logic [OW-1:0] LEBV   = OW'(LEB_CYC);

  logic [OW-1:0] on_q;

  always_ff @(posedge clk) begin
    if (rst || !gate_i)  on_q <= '0;
    else if (on_q != MAX_M1) on_q <= on_q + 1'b1;
  end

  assign off_req_o = gate_i &&
                     ((on_q >= MAX_M1) ||
                      (ton_done_i && on_q >= MIN_M1) ||
                      (ilim_i && on_q >= LEBV));

  // Inside both the blanking and the minimum window nothing ends the pulse
  assert_leb_min_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (gate_i && on_q < LEBV && on_q < MIN_M1) |-> !off_req_o);

  // On-time count tracks the pulse from its first cycle
  assert_on_count_R8: assert property (@(posedge clk) disable iff (rst)
    (gate_i && !off_req_o) |=> (!gate_i || on_q == $past(on_q) + 1'b1));

endmodule

// File: rtl/qr_cycle_sequencer.sv
module qr_cycle_sequencer
  import qr_seq_pkg::*;
#(
  parameter int MIN_PERIOD_CYC     = 425,
  parameter int EXT_CYC            = 250,
  parameter int START_CYC          = 6500,
  parameter int ON_MIN_CYC         = 63,
  parameter int ON_MAX_CYC         = 2350,
  parameter int LEB_CYC            = 20,
  parameter int BLANK_BASE_CYC     = 100,
  parameter int BLANK_PER_CODE_CYC = 1,
  parameter int CODE_W             = 8,
  parameter int SYNC_STAGES        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              valley_in,
  input  logic              on_done,
  input  logic              cur_limit,
  input  logic [CODE_W-1:0] peak_code,
  output logic              gate,
  output logic              cycle_start,
  output logic              cycle_end
);
  gate_phase_e phase_q;
  logic        start_q;
  logic        end_q;
  logic        valley_rise;
  logic        blank_active;
  logic        valley_ok;
  logic        launch;
  logic        off_req;
  logic        gate_on;

  assign gate_on   = (phase_q == PH_ON);
  assign valley_ok = valley_rise && !blank_active && !gate_on;

  qr_valley_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk          (clk),
    .rst          (rst),
    .pulse_async_i(valley_in),
    .rise_o       (valley_rise)
  );

  qr_valley_blank #(
    .BLANK_BASE_CYC    (BLANK_BASE_CYC),
    .BLANK_PER_CODE_CYC(BLANK_PER_CODE_CYC),
    .CODE_W            (CODE_W)
  ) u_blank (
    .clk     (clk),
    .rst     (rst),
    .en_i    (enable),
    .load_i  (off_req),
    .code_i  (peak_code),
    .active_o(blank_active)
  );

  qr_period_timer #(
    .MIN_PERIOD_CYC(MIN_PERIOD_CYC),
    .EXT_CYC       (EXT_CYC),
    .START_CYC     (START_CYC)
  ) u_period (
    .clk     (clk),
    .rst     (rst),
    .en_i    (enable),
    .gate_i  (gate_on),
    .valley_i(valley_ok),
    .launch_o(launch)
  );

  qr_ontime_ctrl #(
    .ON_MIN_CYC(ON_MIN_CYC),
    .ON_MAX_CYC(ON_MAX_CYC),
    .LEB_CYC   (LEB_CYC)
  ) u_ontime (
    .clk       (clk),
    .rst       (rst),
    .gate_i    (gate_on),
    .ton_done_i(on_done),
    .ilim_i    (cur_limit),
    .off_req_o (off_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_OFF;
      start_q <= 1'b0;
      end_q   <= 1'b0;
    end else if (!enable) begin
      phase_q <= PH_OFF;
      start_q <= 1'b0;
      end_q   <= gate_on;
    end else begin
      start_q <= launch;
      end_q   <= gate_on && off_req;
      case (phase_q)
        PH_OFF:  if (launch)  phase_q <= PH_ON;
        PH_ON:   if (off_req) phase_q <= PH_OFF;
        default: phase_q <= PH_OFF;
      endcase
    end
  end

  assign gate        = gate_on;
  assign cycle_start = start_q;
  assign cycle_end   = end_q;

  // Disable forces the gate off on the next edge
  assert_gate_off_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !gate);

  // Start strobe marks exactly the first high cycle
  assert_start_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    cycle_start == $rose(gate));

  // End strobe marks exactly the first low cycle after a pulse
  assert_end_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    cycle_end == $fell(gate));

endmodule

// File: tb/test_qr_cycle_sequencer.sv
`timescale 1ns/1ps
module test_qr_cycle_sequencer;
  localparam int TSMIN  = 40;
  localparam int TEXT   = 12;
  localparam int TSTART = 150;
  localparam int TONMIN = 6;
  localparam int TONMAX = 30;
  localparam int TLEB   = 4;
  localparam int BKBASE = 5;
  localparam int BKCODE = 1;
  localparam int NROWS  = 14;

  // Each row: valley_k, on_done_k, cur_limit_k, peak_code, expected width, expected period
  // (-1 = never driven). Expected values follow from the latencies in the brief.
  localparam int VEC [NROWS][6] = '{
    '{50, 10, -1,  0, 11,  53},
    '{38,  2, -1,  0,  6,  41},
    '{36,  2, -1,  0,  6,  52},
    '{37,  2, -1,  0,  6,  40},
    '{-1, -1, -1,  0, 30, 150},
    '{60, -1,  2,  0,  5,  63},
    '{45, -1,  7,  0,  8,  48},
    '{43, 10, -1, 30, 11, 150},
    '{44, 10, -1, 30, 11,  47},
    '{ 3, 20, -1,  0, 21, 150},
    '{80, 40, -1,  0, 30,  83},
    '{50, 12,  9,  0, 10,  53},
    '{ 8,  2, -1,  0,  6, 150},
    '{ 9,  2, -1,  0,  6,  52}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       valley_in = 1'b0;
  logic       on_done = 1'b0;
  logic       cur_limit = 1'b0;
  logic [7:0] peak_code = '0;
  logic       gate;
  logic       cycle_start;
  logic       cycle_end;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  qr_cycle_sequencer #(
    .MIN_PERIOD_CYC(TSMIN), .EXT_CYC(TEXT), .START_CYC(TSTART),
    .ON_MIN_CYC(TONMIN), .ON_MAX_CYC(TONMAX), .LEB_CYC(TLEB),
    .BLANK_BASE_CYC(BKBASE), .BLANK_PER_CODE_CYC(BKCODE), .CODE_W(8), .SYNC_STAGES(2)
  ) i_qr_cycle_sequencer (
    .clk(clk), .rst(rst), .enable(enable), .valley_in(valley_in),
    .on_done(on_done), .cur_limit(cur_limit), .peak_code(peak_code),
    .gate(gate), .cycle_start(cycle_start), .cycle_end(cycle_end)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string row_tag(input int i);
    case (i)
      0: return "R3 R9";
      1: return "R7 R3";
      2: return "R4 R5";
      3: return "R4 R3";
      4: return "R6 R8";
      5: return "R10";
      6: return "R10";
      7: return "R11";
      8: return "R11";
      9: return "R11";
      10: return "R8";
      11: return "R10 R9";
      12: return "R11";
      default: return "R11 R5";
    endcase
  endfunction

  // Called at the falling edge of the first gate-high cycle (k = 0); returns at the
  // falling edge of the next pulse's first high cycle.
  task automatic run_cycle(input int vly, input int vlen, input int ton, input int ilim,
                           input int code, output int w, output int p,
                           output int st, output int en_s);
    bit done;
    w = -1; p = -1; en_s = 0; done = 0;
    st = int'(cycle_start);
    for (int k = 0; k < 400 && !done; k++) begin
      if (w < 0 && !gate) begin
        w = k;
        en_s = int'(cycle_end);
      end else if (w >= 0 && gate) begin
        p = k;
        done = 1;
      end
      if (!done) begin
        peak_code = 8'(code);
        on_done   = gate && ton >= 0 && k >= ton;
        cur_limit = gate && ilim >= 0 && k >= ilim;
        valley_in = (vly >= 0) && k >= vly && k < vly + vlen;
        @(negedge clk);
      end
    end
    on_done = 1'b0; cur_limit = 1'b0; valley_in = 1'b0;
  endtask

  // Count edges from enable rising to the first gate-high sample
  task automatic launch_after_enable(output int n);
    n = -1;
    enable = 1'b1;
    for (int j = 1; j < 400; j++) begin
      valley_in = (j == 5 || j == 60 || j == 61);
      @(negedge clk);
      if (gate && n < 0) begin
        n = j;
        break;
      end
    end
    valley_in = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog R1..: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int w, p, st, es, n;
    // R1: reset state
    repeat (4) @(negedge clk);
    check_eq("R1 gate in reset", int'(gate), 0);
    check_eq("R1 start strobe in reset", int'(cycle_start), 0);
    check_eq("R1 end strobe in reset", int'(cycle_end), 0);

    // R2: first pulse from the starter, early valley ignored
    rst = 1'b0;
    launch_after_enable(n);
    check_eq("R2 first launch edges", n, TSTART);

    // Table walk: R3..R12
    for (int i = 0; i < NROWS; i++) begin
      run_cycle(VEC[i][0], 1, VEC[i][1], VEC[i][2], VEC[i][3], w, p, st, es);
      check_eq({row_tag(i), " width"}, w, VEC[i][4]);
      check_eq({row_tag(i), " period"}, p, VEC[i][5]);
      check_eq("R12 start strobe", st, 1);
      check_eq("R12 end strobe", es, 1);
    end

    // R13: a valley held high for 50 cycles from k=20 counts once -> fallback period
    run_cycle(20, 50, 2, -1, 0, w, p, st, es);
    check_eq("R13 held valley period", p, TSMIN + TEXT);
    check_eq("R7 width with held valley", w, TONMIN);

    // R1: enable drop while gate high
    enable = 1'b0;
    @(negedge clk);
    check_eq("R1 gate after disable", int'(gate), 0);
    check_eq("R12 end strobe on disable", int'(cycle_end), 1);
    for (int j = 0; j < 12; j++) begin
      valley_in = (j % 3 == 0);
      @(negedge clk);
      if (gate) check_eq("R1 gate stays low while disabled", int'(gate), 0);
    end
    valley_in = 1'b0;
    check_eq("R1 gate low at end of disable", int'(gate), 0);

    // R2: restart after enable returns
    launch_after_enable(n);
    check_eq("R2 relaunch edges", n, TSTART);
    check_eq("R12 start strobe after relaunch", int'(cycle_start), 1);

    // R1: synchronous reset while gate high
    rst = 1'b1;
    @(negedge clk);
    check_eq("R1 gate after reset", int'(gate), 0);
    check_eq("R1 start strobe after reset", int'(cycle_start), 0);
    check_eq("R1 end strobe after reset", int'(cycle_end), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule